// File: doc/BRIEF.md
# Dual-Mode Timer Counter Core

This block is a free-running up-counter with a small word-addressed register port. Software writes a control word to start or stop counting, picks an optional power-of-two clock divider and chooses whether the counter reloads from a load register or stops when it wraps. Alongside counting, it compares the counter against a match value and can latch the counter value when an external input changes. It raises match, overflow and capture flags that combine into one interrupt line.

A single output pin carries a waveform derived from counter events. The pin either toggles or emits a short pulse on overflow, or on overflow and match. A default level and a forced-level option set what the pin shows when no waveform runs. All configuration lives in one control word, so a single write reconfigures the timer.

Top module: `dmt_core`

## Requirements
- R1: While control bit 0 is set, the counter advances by one on every divider tick. From the first clock edge after a write that clears bit 0, the counter holds its value, which is well inside 3.5 clock periods.
- R2: With control bit 5 clear, the divider ticks every clock. With bit 5 set, it ticks once every 2^(v+1) clocks, where v is control bits 4:2, and the first tick comes that many clocks after start.
- R3: A tick at the all-ones count sets raw flag bit 1. If control bit 1 is set, the counter reloads from the load register (word 2). Otherwise it wraps to zero and control bit 0 clears.
- R4: With control bit 6 set, a tick that brings the counter to the match register (word 4) sets raw flag bit 0. With bit 6 clear, no match flag is raised.
- R5: A write of any value to word 3 copies the load register into the counter. A write to word 1 sets the counter directly.
- R6: Control bits 9:8 select which capture input edges count as events: 00 none, 01 rising, 10 falling, 11 both. The input passes through a two-flop synchroniser. In single mode (control bit 13 clear), each event copies the counter into word 5 and sets raw flag bit 2.
- R7: In dual mode (control bit 13 set), the first event fills word 5 and raises no flag. The second event fills word 6 and sets raw flag bit 2.
- R8: Word 7 reads the raw flags. Word 8 reads the flags ANDed with the enables, and writing 1s to word 8 clears those raw flags. Writing 1s to word 9 sets enable bits, and writing 1s to word 10 clears them. Words 9 and 10 both read the enables. The irq output is registered and goes high one clock after any enabled flag is set.
- R9: Control bits 11:10 pick the waveform trigger: 00 none, 01 overflow, 1x overflow or match. With control bit 12 set, each trigger toggles the waveform state. The pin shows control bit 7 XOR the state, and the state clears while the trigger is 00.
- R10: With control bit 12 clear, each trigger inverts the pin against control bit 7 for exactly one divider period (2^(v+1) clocks, or one clock with the divider off).
- R11: With control bit 14 set, the pin is forced to the level of control bit 7 whatever events occur.
- R12: After reset, all registers, the irq output and the pin are 0. Reads are registered and return the addressed word one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Registered read data |
| cap_in | input | 1 | Asynchronous capture input |
| pwm_out | output | 1 | Registered waveform pin |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench counts exact tick totals across start and stop writes. A divider that is off by one, or a stop that takes more than one edge, leaves the frozen count wrong. Overflow is exercised three ways: wrapping into a reload value, wrapping into one-shot stop, and toggling the pin. A design that forgets to clear the start bit, or reloads zero instead of the load value, is caught. Capture is driven with each edge selection and in dual mode, so a design that flags on the first dual event or captures on the wrong edge reports a FAIL. Pulse width is measured cycle by cycle against the divider ratio, and the forced-level option is checked while toggle events keep arriving.

// File: rtl/dmt_pkg.sv
`timescale 1ns/1ps
package dmt_pkg;
  localparam int unsigned PSC_W  = 3;
  localparam int unsigned CTRL_W = 15;
  localparam int unsigned IRQ_W  = 3;
  localparam int unsigned FL_MATCH = 0;
  localparam int unsigned FL_OVF   = 1;
  localparam int unsigned FL_CAP   = 2;

  typedef enum logic [3:0] {
    RG_CTRL  = 4'd0,
    RG_COUNT = 4'd1,
    RG_LOAD  = 4'd2,
    RG_TRIG  = 4'd3,
    RG_MATCH = 4'd4,
    RG_CAPA  = 4'd5,
    RG_CAPB  = 4'd6,
    RG_RAW   = 4'd7,
    RG_STAT  = 4'd8,
    RG_ENSET = 4'd9,
    RG_ENCLR = 4'd10
  } reg_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_e;

  typedef struct packed {
    logic             force_lvl;
    logic             dual_cap;
    logic             toggle;
    logic [1:0]       wave_trig;
    edge_e            cap_edge;
    logic             idle_lvl;
    logic             cmp_en;
    logic             div_en;
    logic [PSC_W-1:0] div_sel;
    logic             reload;
    logic             run;
  } ctrl_t;
endpackage

// File: rtl/dmt_prescale.sv
`timescale 1ns/1ps
module dmt_prescale #(
  parameter int unsigned PSC_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     run,
  input  logic                     div_en,
  input  logic [PSC_W-1:0]         div_sel,
  output logic                     tick,
  output logic [(1<<PSC_W):0]      ratio
);
  localparam int unsigned DIV_W = (1 << PSC_W) + 1;

  logic [DIV_W-1:0] div_q;
  logic [PSC_W:0]   shamt;

  always_comb begin
    shamt = {1'b0, div_sel} + (PSC_W+1)'(1);
    ratio = div_en ? (DIV_W'(1) << shamt) : DIV_W'(1);
    tick  = run && (div_q == ratio - DIV_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || !run || tick) div_q <= '0;
    else                     div_q <= div_q + DIV_W'(1);
  end

  // R2: with the divider on, two ticks never fall on adjacent clocks
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (tick && div_en) |=> (!tick || !div_en));

  // R1: no ticks while stopped
  a_r1_no_tick_stopped: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick);
endmodule

// File: rtl/dmt_capture.sv
`timescale 1ns/1ps
module dmt_capture
  import dmt_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin,
  input  edge_e            edge_sel,
  input  logic             dual,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_a,
  output logic [CNT_W-1:0] cap_b,
  output logic             flag
);
  logic [SYNC_STAGES:0] sh_q;
  logic rise, fall, evt, second_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SYNC_STAGES-1:0], pin};
  end

  always_comb begin
    rise = sh_q[SYNC_STAGES-1] && !sh_q[SYNC_STAGES];
    fall = !sh_q[SYNC_STAGES-1] && sh_q[SYNC_STAGES];
    unique case (edge_sel)
      EDGE_RISE: evt = rise;
      EDGE_FALL: evt = fall;
      EDGE_BOTH: evt = rise || fall;
      default:   evt = 1'b0;
    endcase
    flag = evt && (!dual || second_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_a    <= '0;
      cap_b    <= '0;
      second_q <= 1'b0;
    end else begin
      if (!dual || edge_sel == EDGE_NONE) second_q <= 1'b0;
      else if (evt)                       second_q <= !second_q;
      if (evt) begin
        if (dual && second_q) cap_b <= cnt;
        else                  cap_a <= cnt;
      end
    end
  end

  // R6: the first capture word only changes on an event
  a_r6_hold_a: assert property (@(posedge clk) disable iff (rst)
    !evt |=> $stable(cap_a));

  // R7: the second capture word is untouched in single mode
  a_r7_hold_b: assert property (@(posedge clk) disable iff (rst)
    !dual |=> $stable(cap_b));
endmodule

// File: rtl/dmt_wave.sv
`timescale 1ns/1ps
module dmt_wave #(
  parameter int unsigned DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ovf,
  input  logic             match,
  input  logic [1:0]       trig,
  input  logic             toggle,
  input  logic             idle_lvl,
  input  logic             force_lvl,
  input  logic [DIV_W-1:0] ratio,
  output logic             pin
);
  logic [DIV_W-1:0] pcnt_q;
  logic tog_q, evt, pulse_on;

  always_comb begin
    evt      = (ovf && trig != 2'b00) || (match && trig[1]);
    pulse_on = (pcnt_q != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_q  <= 1'b0;
      pcnt_q <= '0;
      pin    <= 1'b0;
    end else begin
      if (trig == 2'b00)       tog_q <= 1'b0;
      else if (evt && toggle)  tog_q <= !tog_q;
      if (evt && !toggle)      pcnt_q <= ratio;
      else if (pulse_on)       pcnt_q <= pcnt_q - DIV_W'(1);
      pin <= force_lvl ? idle_lvl : (idle_lvl ^ (toggle ? tog_q : pulse_on));
    end
  end

  // R11: forced level wins over any event
  a_r11_forced: assert property (@(posedge clk) disable iff (rst)
    (force_lvl && idle_lvl) |=> pin);

  // R10: a pulse window only opens on an event
  a_r10_pulse_start: assert property (@(posedge clk) disable iff (rst)
    (!pulse_on && !evt) |=> !pulse_on);
endmodule

// File: rtl/dmt_core.sv
`timescale 1ns/1ps
module dmt_core
  import dmt_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [3:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             cap_in,
  output logic             pwm_out,
  output logic             irq
);
  localparam int unsigned DIV_W = (1 << PSC_W) + 1;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt_q, load_q, match_q, cnt_adv, cap_a, cap_b;
  logic [IRQ_W-1:0] raw_q, en_q, set_v, clr_v;
  logic [DIV_W-1:0] ratio;
  logic tick, ovf, match_hit, cap_hit;
  logic wr_ctrl, wr_cnt, wr_load, wr_trig, wr_match, wr_stat, wr_enset, wr_enclr;

  always_comb begin
    wr_ctrl  = bus_wr && bus_addr == RG_CTRL;
    wr_cnt   = bus_wr && bus_addr == RG_COUNT;
    wr_load  = bus_wr && bus_addr == RG_LOAD;
    wr_trig  = bus_wr && bus_addr == RG_TRIG;
    wr_match = bus_wr && bus_addr == RG_MATCH;
    wr_stat  = bus_wr && bus_addr == RG_STAT;
    wr_enset = bus_wr && bus_addr == RG_ENSET;
    wr_enclr = bus_wr && bus_addr == RG_ENCLR;
  end

  dmt_prescale #(.PSC_W(PSC_W)) u_div (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .div_en(ctrl_q.div_en),
    .div_sel(ctrl_q.div_sel), .tick(tick), .ratio(ratio)
  );

  always_comb begin
    ovf       = tick && (cnt_q == '1);
    cnt_adv   = ovf ? (ctrl_q.reload ? load_q : '0) : cnt_q + CNT_W'(1);
    match_hit = tick && ctrl_q.cmp_en && (cnt_adv == match_q);
  end

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (wr_cnt)  cnt_q <= bus_wdata;
    else if (wr_trig) cnt_q <= load_q;
    else if (tick)    cnt_q <= cnt_adv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      match_q <= '0;
    end else begin
      if (wr_ctrl)                     ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      else if (ovf && !ctrl_q.reload)  ctrl_q.run <= 1'b0;
      if (wr_load)  load_q  <= bus_wdata;
      if (wr_match) match_q <= bus_wdata;
    end
  end

  dmt_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk(clk), .rst(rst), .pin(cap_in), .edge_sel(ctrl_q.cap_edge),
    .dual(ctrl_q.dual_cap), .cnt(cnt_q), .cap_a(cap_a), .cap_b(cap_b),
    .flag(cap_hit)
  );

  dmt_wave #(.DIV_W(DIV_W)) u_wave (
    .clk(clk), .rst(rst), .ovf(ovf), .match(match_hit),
    .trig(ctrl_q.wave_trig), .toggle(ctrl_q.toggle),
    .idle_lvl(ctrl_q.idle_lvl), .force_lvl(ctrl_q.force_lvl),
    .ratio(ratio), .pin(pwm_out)
  );

  always_comb begin
    set_v = '0;
    set_v[FL_MATCH] = match_hit;
    set_v[FL_OVF]   = ovf;
    set_v[FL_CAP]   = cap_hit;
    clr_v = wr_stat ? bus_wdata[IRQ_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      en_q  <= '0;
      irq   <= 1'b0;
    end else begin
      raw_q <= (raw_q & ~clr_v) | set_v;
      if (wr_enset)      en_q <= en_q | bus_wdata[IRQ_W-1:0];
      else if (wr_enclr) en_q <= en_q & ~bus_wdata[IRQ_W-1:0];
      irq <= |(raw_q & en_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      unique case (bus_addr)
        RG_CTRL:  bus_rdata <= {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
        RG_COUNT: bus_rdata <= cnt_q;
        RG_LOAD:  bus_rdata <= load_q;
        RG_MATCH: bus_rdata <= match_q;
        RG_CAPA:  bus_rdata <= cap_a;
        RG_CAPB:  bus_rdata <= cap_b;
        RG_RAW:   bus_rdata <= {{(CNT_W-IRQ_W){1'b0}}, raw_q};
        RG_STAT:  bus_rdata <= {{(CNT_W-IRQ_W){1'b0}}, raw_q & en_q};
        RG_ENSET, RG_ENCLR: bus_rdata <= {{(CNT_W-IRQ_W){1'b0}}, en_q};
        default:  bus_rdata <= '0;
      endcase
    end
  end

  // R1: a stopped counter holds unless software writes it
  a_r1_frozen: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.run && !wr_cnt && !wr_trig) |=> $stable(cnt_q));

  // R3: an overflow always leaves its raw flag set
  a_r3_ovf_flag: assert property (@(posedge clk) disable iff (rst)
    ovf |=> raw_q[FL_OVF]);

  // R3: one-shot wrap stops the counter at zero
  a_r3_oneshot: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ctrl_q.reload && !bus_wr) |=> (!ctrl_q.run && cnt_q == '0));

  // R5: a reload write copies the load word
  a_r5_reload: assert property (@(posedge clk) disable iff (rst)
    wr_trig |=> cnt_q == $past(load_q));

  // R8: with nothing enabled the interrupt stays low
  a_r8_masked: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq);
endmodule

// File: tb/dmt_core_test.sv
`timescale 1ns/1ps
module dmt_core_test;
  import dmt_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        cap_in = 1'b0;
  logic        pwm_out, irq;
  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dmt_core #(.CNT_W(32), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .pwm_out(pwm_out), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input reg_e a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input reg_e a, output logic [31:0] v);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R12 pwm after reset", {31'd0, pwm_out}, 32'd0);
    chk("R12 irq after reset", {31'd0, irq}, 32'd0);
    rd(RG_CTRL, v);  chk("R12 ctrl after reset", v, 32'd0);
    rd(RG_COUNT, v); chk("R12 count after reset", v, 32'd0);
    rd(RG_RAW, v);   chk("R12 raw after reset", v, 32'd0);
  endtask

  task automatic t_run_stop();
    logic [31:0] v;
    wr(RG_COUNT, 32'd100);
    wr(RG_CTRL, 32'h1);
    idle(9);
    wr(RG_CTRL, 32'h0);
    rd(RG_COUNT, v); chk("R1 count after 10 ticks", v, 32'd110);
    idle(3);
    rd(RG_COUNT, v); chk("R1 counter frozen after stop", v, 32'd110);
  endtask

  task automatic t_divider();
    logic [31:0] v;
    wr(RG_COUNT, 32'd0);
    wr(RG_CTRL, 32'h21);
    idle(19);
    wr(RG_CTRL, 32'h0);
    rd(RG_COUNT, v); chk("R2 divide by 2", v, 32'd10);
    wr(RG_COUNT, 32'd0);
    wr(RG_CTRL, 32'h29);
    idle(39);
    wr(RG_CTRL, 32'h0);
    rd(RG_COUNT, v); chk("R2 divide by 8", v, 32'd5);
  endtask

  task automatic t_reload();
    logic [31:0] v;
    wr(RG_STAT, 32'h7);
    wr(RG_COUNT, 32'hFFFF_FFFD);
    wr(RG_LOAD, 32'h10);
    wr(RG_CTRL, 32'h3);
    idle(4);
    wr(RG_CTRL, 32'h0);
    rd(RG_COUNT, v); chk("R3 reload value after wrap", v, 32'h12);
    rd(RG_RAW, v);   chk("R3 overflow flag", v, 32'h2);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    idle(2);
    chk("R8 irq low while masked", {31'd0, irq}, 32'd0);
    rd(RG_STAT, v); chk("R8 masked status", v, 32'd0);
    wr(RG_ENSET, 32'h2);
    idle(2);
    chk("R8 irq after enable", {31'd0, irq}, 32'd1);
    rd(RG_STAT, v); chk("R8 enabled status", v, 32'h2);
    wr(RG_ENCLR, 32'h2);
    idle(2);
    chk("R8 irq after enable clear", {31'd0, irq}, 32'd0);
    rd(RG_ENSET, v); chk("R8 enables cleared", v, 32'd0);
    rd(RG_RAW, v);   chk("R8 raw kept when masked", v, 32'h2);
    wr(RG_ENSET, 32'h2);
    wr(RG_STAT, 32'h2);
    idle(2);
    chk("R8 irq after write-1 clear", {31'd0, irq}, 32'd0);
    rd(RG_RAW, v); chk("R8 raw cleared", v, 32'd0);
    wr(RG_ENCLR, 32'h7);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    wr(RG_STAT, 32'h7);
    wr(RG_COUNT, 32'hFFFF_FFFE);
    wr(RG_CTRL, 32'h1);
    idle(5);
    rd(RG_CTRL, v);  chk("R3 one-shot clears start", v, 32'h0);
    rd(RG_COUNT, v); chk("R3 one-shot wraps to zero", v, 32'h0);
    rd(RG_RAW, v);   chk("R3 one-shot overflow flag", v, 32'h2);
  endtask

  task automatic t_match();
    logic [31:0] v;
    wr(RG_STAT, 32'h7);
    wr(RG_COUNT, 32'h100);
    wr(RG_MATCH, 32'h105);
    wr(RG_CTRL, 32'h41);
    idle(5);
    wr(RG_CTRL, 32'h0);
    rd(RG_COUNT, v); chk("R4 count past match", v, 32'h106);
    rd(RG_RAW, v);   chk("R4 match flag", v, 32'h1);
    wr(RG_STAT, 32'h7);
    wr(RG_COUNT, 32'h100);
    wr(RG_CTRL, 32'h1);
    idle(5);
    wr(RG_CTRL, 32'h0);
    rd(RG_RAW, v);   chk("R4 no flag with compare off", v, 32'h0);
  endtask

  task automatic t_trigger();
    logic [31:0] v;
    wr(RG_LOAD, 32'h55);
    wr(RG_COUNT, 32'h1234);
    rd(RG_COUNT, v); chk("R5 direct counter write", v, 32'h1234);
    wr(RG_TRIG, 32'hDEAD);
    rd(RG_COUNT, v); chk("R5 trigger reloads counter", v, 32'h55);
  endtask

  task automatic t_capture();
    logic [31:0] v;
    wr(RG_STAT, 32'h7);
    wr(RG_CTRL, 32'h0);
    wr(RG_COUNT, 32'h200);
    cap_in = 1'b1; idle(5);
    rd(RG_RAW, v);  chk("R6 no event with edge none", v, 32'h0);
    rd(RG_CAPA, v); chk("R6 capture word untouched", v, 32'h0);
    cap_in = 1'b0; idle(5);
    wr(RG_CTRL, 32'h100);
    cap_in = 1'b1; idle(5);
    rd(RG_CAPA, v); chk("R6 rising capture value", v, 32'h200);
    rd(RG_RAW, v);  chk("R6 rising capture flag", v, 32'h4);
    wr(RG_STAT, 32'h7);
    wr(RG_CTRL, 32'h200);
    wr(RG_COUNT, 32'h300);
    cap_in = 1'b0; idle(5);
    rd(RG_CAPA, v); chk("R6 falling capture value", v, 32'h300);
    wr(RG_STAT, 32'h7);
    cap_in = 1'b1; idle(5);
    rd(RG_RAW, v);  chk("R6 rising edge ignored in falling mode", v, 32'h0);
  endtask

  task automatic t_dual();
    logic [31:0] v;
    wr(RG_CTRL, 32'h2300);
    wr(RG_COUNT, 32'h400);
    cap_in = 1'b0; idle(5);
    rd(RG_CAPA, v); chk("R7 first event fills word 5", v, 32'h400);
    rd(RG_RAW, v);  chk("R7 no flag on first event", v, 32'h0);
    wr(RG_COUNT, 32'h401);
    cap_in = 1'b1; idle(5);
    rd(RG_CAPB, v); chk("R7 second event fills word 6", v, 32'h401);
    rd(RG_CAPA, v); chk("R7 word 5 kept", v, 32'h400);
    rd(RG_RAW, v);  chk("R7 flag on second event", v, 32'h4);
    wr(RG_CTRL, 32'h0);
    wr(RG_STAT, 32'h7);
  endtask

  task automatic t_toggle();
    wr(RG_COUNT, 32'hFFFF_FFFE);
    wr(RG_LOAD, 32'hFFFF_FFFE);
    wr(RG_CTRL, 32'h1403);
    idle(1);
    wr(RG_CTRL, 32'h1402);
    idle(2);
    chk("R9 toggle after one overflow", {31'd0, pwm_out}, 32'd1);
    wr(RG_CTRL, 32'h80);
    idle(2);
    chk("R9 idle level with trigger none", {31'd0, pwm_out}, 32'd1);
    wr(RG_CTRL, 32'h0);
    idle(2);
    chk("R9 idle level low", {31'd0, pwm_out}, 32'd0);
    wr(RG_COUNT, 32'hFFFF_FFFD);
    wr(RG_MATCH, 32'hFFFF_FFFE);
    wr(RG_CTRL, 32'h1843);
    wr(RG_CTRL, 32'h1842);
    idle(2);
    chk("R9 toggle on match with trigger 10", {31'd0, pwm_out}, 32'd1);
    wr(RG_CTRL, 32'h0);
    idle(2);
    wr(RG_COUNT, 32'hFFFF_FFFD);
    wr(RG_CTRL, 32'h1443);
    wr(RG_CTRL, 32'h1442);
    idle(2);
    chk("R9 match ignored with trigger 01", {31'd0, pwm_out}, 32'd0);
    wr(RG_CTRL, 32'h0);
    idle(2);
  endtask

  task automatic t_pulse();
    int hi = 0;
    wr(RG_COUNT, 32'hFFFF_FFF0);
    wr(RG_LOAD, 32'hFFFF_FFF0);
    wr(RG_CTRL, 32'h423);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    wr(RG_CTRL, 32'h0);
    chk("R10 pulse lasts one divider period", hi, 32'd2);
  endtask

  task automatic t_force();
    int hi = 0;
    wr(RG_COUNT, 32'hFFFF_FFFE);
    wr(RG_LOAD, 32'hFFFF_FFFE);
    wr(RG_CTRL, 32'h5483);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    chk("R11 forced high despite toggles", hi, 32'd8);
    wr(RG_CTRL, 32'h5402);
    idle(2);
    chk("R11 forced low", {31'd0, pwm_out}, 32'd0);
    wr(RG_CTRL, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_run_stop();
    t_divider();
    t_reload();
    t_irq();
    t_oneshot();
    t_match();
    t_trigger();
    t_capture();
    t_dual();
    t_toggle();
    t_pulse();
    t_force();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule